// File: doc/BRIEF.md
# External Interrupt Sense Controller

This peripheral sits on a small microcontroller-style I/O bus and turns one external interrupt pin into an interrupt request line for the CPU. An 8-bit control register at a fixed I/O address selects how the pin is sensed. The options are low level, falling edge or rising edge. The pin passes through a two-flop synchroniser, and edges are found by comparing consecutive synchronised samples. An edge sets a pending flag, which stays set until the core acknowledges it or software strobes a clear. In level mode the request follows the pin directly and nothing is latched. The request reaches the core only when both the global interrupt-enable input and this source's mask input are high.

The same register holds a sleep-enable bit and a sleep-mode select bit. Both are driven out to a power manager outside this block. A sleep command from the core is passed on only while sleep-enable is set.

Top module: `extint_sense_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00, and `irq_req`, `sleep_en`, `sleep_pd` and `sleep_go` are all 0.
- R2: The control register is at bus address 0x35. Bits 7, 6, 3 and 2 always read 0 and ignore writes. Bits 5, 4, 1 and 0 are read/write. A read of any other address returns 0, and a write to any other address has no effect.
- R3: Register bit 5 drives `sleep_en`. Register bit 4 drives `sleep_pd`, where 0 means idle and 1 means power-down.
- R4: `sleep_go` equals `sleep_cmd` while bit 5 is 1, and is 0 otherwise.
- R5: Sense code 00 (bits 1:0) is low level. `irq_req` rises two clocks after the pin goes low and falls two clocks after the pin returns high. It is not latched.
- R6: Sense code 10 sets the pending flag on a falling edge, and sense code 11 sets it on a rising edge. The request appears three clocks after the pin changes. An edge in the opposite direction sets nothing.
- R7: A pending edge stays set until `irq_ack` or `pend_clr` is pulsed. It is gone on the clock after the pulse.
- R8: Sense code 01 is reserved and never produces a request.
- R9: `irq_req` is 1 only when `gie` and `irq_mask` are both 1. An edge seen while the request is gated is still held pending and shows up once the gate opens.
- R10: A register write that changes bits 1:0 clears the pending flag. A write that keeps the same code does not clear it.
- R11: A pin pulse that lasts two clocks is enough to register an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 6 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for the current address |
| gie | input | 1 | Global interrupt enable |
| irq_mask | input | 1 | Mask bit for this source |
| irq_pin | input | 1 | Asynchronous external interrupt pin |
| irq_ack | input | 1 | Core acknowledge; clears the pending edge |
| pend_clr | input | 1 | Software clear strobe for the pending edge |
| sleep_cmd | input | 1 | Sleep instruction executed |
| irq_req | output | 1 | Interrupt request to the core |
| sleep_en | output | 1 | Sleep enable bit |
| sleep_pd | output | 1 | Sleep mode: 0 idle, 1 power-down |
| sleep_go | output | 1 | Qualified sleep request to the power manager |

## Verification
The register is swept through all 256 write values. This separates the writable bits from the reserved ones and shows that the sleep outputs follow their bits. For each sense code, the bench drives a two-clock pulse, a single one-way transition and a held low level, under all four combinations of `gie` and `irq_mask`. These patterns tell edge polarity apart, latched behaviour apart from level behaviour, and gated requests apart from lost ones. Checks placed at one and two clocks after a pin change pin down the synchroniser latency. Rewriting the sense code with the same value and with a new value separates the two cases for clearing the pending flag.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int REG_W   = 8;
  localparam int BIT_SE  = 5;
  localparam int BIT_SM  = 4;
  localparam logic [REG_W-1:0] WR_MASK = 8'h33;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RSVD = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  function automatic logic [REG_W-1:0] reg_pack(input logic se, input logic sm,
                                                input logic [1:0] code);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_SE] = se;
    v[BIT_SM] = sm;
    v[1:0] = code;
    return v;
  endfunction

  function automatic logic edge_match(input sense_e mode, input logic prev,
                                      input logic cur);
    logic hit;
    case (mode)
      SENSE_FALL: hit = prev & ~cur;
      SENSE_RISE: hit = ~prev & cur;
      default:    hit = 1'b0;
    endcase
    return hit;
  endfunction

  function automatic logic level_match(input sense_e mode, input logic cur);
    return (mode == SENSE_LOW) && !cur;
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RESET_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/extint_ctl_reg.sv
module extint_ctl_reg
  import extint_pkg::*;
#(
  parameter int               ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              sleep_en,
  output logic              sleep_pd,
  output sense_e            sense,
  output logic              mode_chg
);
  logic             hit;
  logic             wr_en;
  logic [REG_W-1:0] wr_val;
  logic             se_q, sm_q;
  sense_e           code_q;

  assign hit    = (bus_addr == CTRL_ADDR);
  assign wr_en  = hit & bus_we;
  assign wr_val = bus_wdata & WR_MASK;

  // a write carrying a new sense code invalidates any edge seen under the old one
  assign mode_chg = wr_en && (sense_e'(wr_val[1:0]) != code_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      se_q   <= 1'b0;
      sm_q   <= 1'b0;
      code_q <= SENSE_LOW;
    end else if (wr_en) begin
      se_q   <= wr_val[BIT_SE];
      sm_q   <= wr_val[BIT_SM];
      code_q <= sense_e'(wr_val[1:0]);
    end
  end

  assign bus_rdata = hit ? reg_pack(se_q, sm_q, code_q) : '0;
  assign sleep_en  = se_q;
  assign sleep_pd  = sm_q;
  assign sense     = code_q;
endmodule

// File: rtl/extint_edge_pend.sv
module extint_edge_pend
  import extint_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   smp,
  input  sense_e mode,
  input  logic   clr,
  output logic   edge_hit,
  output logic   level_hit,
  output logic   pending
);
  logic prev_q;

  assign edge_hit  = edge_match(mode, prev_q, smp);
  assign level_hit = level_match(mode, smp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      pending <= 1'b0;
    end else begin
      prev_q <= smp;
      if (clr)           pending <= 1'b0;
      else if (edge_hit) pending <= 1'b1;
    end
  end
endmodule

// File: rtl/extint_sense_ctrl.sv
module extint_sense_ctrl
  import extint_pkg::*;
#(
  parameter int                ADDR_W      = 6,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 6'h35,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        bus_rdata,
  input  logic              gie,
  input  logic              irq_mask,
  input  logic              irq_pin,
  input  logic              irq_ack,
  input  logic              pend_clr,
  input  logic              sleep_cmd,
  output logic              irq_req,
  output logic              sleep_en,
  output logic              sleep_pd,
  output logic              sleep_go
);
  sense_e sense;
  logic   mode_chg;
  logic   pin_s;
  logic   edge_hit, level_hit, pending;
  logic   pend_wipe;
  logic   gate_open;

  extint_ctl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .sleep_en(sleep_en),
    .sleep_pd(sleep_pd), .sense(sense), .mode_chg(mode_chg)
  );

  extint_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_pin), .q(pin_s)
  );

  assign pend_wipe = irq_ack | pend_clr | mode_chg;

  extint_edge_pend u_pend (
    .clk(clk), .rst_n(rst_n), .smp(pin_s), .mode(sense), .clr(pend_wipe),
    .edge_hit(edge_hit), .level_hit(level_hit), .pending(pending)
  );

  assign gate_open = gie & irq_mask;
  assign irq_req   = gate_open & (level_hit | pending);
  assign sleep_go  = sleep_cmd & sleep_en;
endmodule

// File: rtl/extint_sense_chk.sv
module extint_sense_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_rdata,
  input logic       gie,
  input logic       irq_mask,
  input logic       irq_req,
  input logic       sleep_en,
  input logic       sleep_go,
  input logic [1:0] code,
  input logic       pending,
  input logic       mode_chg
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & 8'hCC) == 8'h00);

  a_r4_sleep_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_go |-> sleep_en);

  a_r6_pend_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> code[1]);

  a_r8_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 2'b01) |-> !irq_req);

  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (gie && irq_mask));

  a_r10_mode_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !pending);
endmodule

bind extint_sense_ctrl extint_sense_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rdata(bus_rdata), .gie(gie),
  .irq_mask(irq_mask), .irq_req(irq_req), .sleep_en(sleep_en),
  .sleep_go(sleep_go), .code(sense), .pending(pending), .mode_chg(mode_chg)
);

// File: tb/extint_sense_ctrl_tb.sv
`timescale 1ns/1ps
module extint_sense_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       gie = 1'b0, irq_mask = 1'b0, irq_pin = 1'b1;
  logic       irq_ack = 1'b0, pend_clr = 1'b0, sleep_cmd = 1'b0;
  logic       irq_req, sleep_en, sleep_pd, sleep_go;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  extint_sense_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .gie(gie), .irq_mask(irq_mask),
    .irq_pin(irq_pin), .irq_ack(irq_ack), .pend_clr(pend_clr),
    .sleep_cmd(sleep_cmd), .irq_req(irq_req), .sleep_en(sleep_en),
    .sleep_pd(sleep_pd), .sleep_go(sleep_go)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick(1);
    bus_we = 1'b0; bus_addr = 6'h35;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_clr();
    pend_clr = 1'b1; tick(1); pend_clr = 1'b0;
  endtask

  // edge modes: idle level, two-clock pulse, gated and ungated
  task automatic edge_trial(input logic [1:0] code, input logic g, input logic k);
    logic idle;
    idle = (code == 2'b11) ? 1'b0 : 1'b1;
    gie = 1'b0; irq_mask = 1'b0;
    irq_pin = idle; tick(4);
    wr(6'h35, {6'b0, code});
    tick(3); pulse_clr();
    gie = g; irq_mask = k;
    irq_pin = ~idle; tick(1);
    chk("R6 no early request", {7'b0, irq_req}, 8'h0);
    tick(1);
    irq_pin = idle; tick(3);
    chk("R11/R6 two-clock pulse edge request", {7'b0, irq_req}, {7'b0, g & k});
    gie = 1'b1; irq_mask = 1'b1; #1;
    chk("R9 pending kept while gated", {7'b0, irq_req}, 8'h1);
    tick(5);
    chk("R7 pending held", {7'b0, irq_req}, 8'h1);
    irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
    chk("R7 ack clears", {7'b0, irq_req}, 8'h0);
    tick(4);
    chk("R6 return edge ignored", {7'b0, irq_req}, 8'h0);
  endtask

  initial begin
    logic [7:0] r;
    tick(3);
    rd(6'h35, r);
    chk("R1 reset reg", r, 8'h00);
    chk("R1 reset outs", {4'b0, irq_req, sleep_en, sleep_pd, sleep_go}, 8'h0);
    rst_n = 1'b1; tick(2);
    rd(6'h35, r);
    chk("R1 reg after reset", r, 8'h00);

    // register sweep
    for (int v = 0; v < 256; v++) begin
      wr(6'h35, v[7:0]);
      rd(6'h35, r);
      chk("R2 rw mask", r, v[7:0] & 8'h33);
      chk("R3 sleep bits", {6'b0, sleep_en, sleep_pd}, {6'b0, v[5], v[4]});
      sleep_cmd = 1'b1; #1;
      chk("R4 sleep_go", {7'b0, sleep_go}, {7'b0, v[5]});
      sleep_cmd = 1'b0;
    end
    wr(6'h35, 8'h31);
    wr(6'h34, 8'hFF);
    rd(6'h35, r);
    chk("R2 other address no write", r, 8'h31);
    rd(6'h34, r);
    chk("R2 other address reads zero", r, 8'h00);
    wr(6'h35, 8'h00);

    // edge modes
    for (int c = 2; c < 4; c++)
      for (int g = 0; g < 2; g++)
        for (int k = 0; k < 2; k++)
          edge_trial(c[1:0], g[0], k[0]);

    // opposite single transition in rising mode
    gie = 1'b1; irq_mask = 1'b1;
    irq_pin = 1'b1; tick(4); pulse_clr();
    irq_pin = 1'b0; tick(5);
    chk("R6 falling ignored in rise mode", {7'b0, irq_req}, 8'h0);

    // level mode
    for (int g = 0; g < 2; g++)
      for (int k = 0; k < 2; k++) begin
        gie = 1'b0; irq_mask = 1'b0;
        irq_pin = 1'b1; tick(3);
        wr(6'h35, 8'h00); pulse_clr(); tick(2);
        gie = g[0]; irq_mask = k[0];
        irq_pin = 1'b0; tick(1);
        chk("R5 one clock latency not yet", {7'b0, irq_req}, 8'h0);
        tick(1);
        chk("R5 level request", {7'b0, irq_req}, {7'b0, g[0] & k[0]});
        tick(4);
        chk("R5 level held", {7'b0, irq_req}, {7'b0, g[0] & k[0]});
        irq_pin = 1'b1; tick(2);
        chk("R5 not latched", {7'b0, irq_req}, 8'h0);
      end

    // reserved code
    gie = 1'b1; irq_mask = 1'b1;
    wr(6'h35, 8'h01);
    irq_pin = 1'b0; tick(4);
    chk("R8 reserved low", {7'b0, irq_req}, 8'h0);
    irq_pin = 1'b1; tick(4);
    chk("R8 reserved edges", {7'b0, irq_req}, 8'h0);

    // mode change clearing
    wr(6'h35, 8'h02); pulse_clr();
    irq_pin = 1'b0; tick(2); irq_pin = 1'b1; tick(3);
    chk("R10 setup pending", {7'b0, irq_req}, 8'h1);
    wr(6'h35, 8'h32);
    chk("R10 same code keeps pending", {7'b0, irq_req}, 8'h1);
    wr(6'h35, 8'h03);
    chk("R10 new code clears", {7'b0, irq_req}, 8'h0);
    wr(6'h35, 8'h02); pulse_clr();
    irq_pin = 1'b0; tick(2); irq_pin = 1'b1; tick(3);
    pend_clr = 1'b1; tick(1); pend_clr = 1'b0;
    chk("R7 pend_clr clears", {7'b0, irq_req}, 8'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule